// File: doc/BRIEF.md
# Panel Power-Up Sequencer

This block brings a display panel out of power-off in a controlled order. Once the supply is reported good and no sleep is requested, it holds the panel's global reset line low for a programmable number of clock cycles. It then releases the reset and waits for a settling interval in which the video timing inputs are expected to stay still.

After settling, the block counts falling edges of the active-low vertical sync input. It turns on four subsystems at fixed positions in that count: the analog supply, the charge pump clock, the panel control and data outputs, and the backlight boost PWM. A done flag reports that all four are on.

A sleep request or a loss of power-good switches every enable off in the same cycle and sends the sequencer back to its idle reset state. When the condition clears, the whole start-up runs again from the reset pulse.

Top module: `panel_pwrseq`

## Requirements
- R1: During and after `rst_n` low, while power-good is low, `panel_rst_n_o` is 0 and all four enables and `seq_done_o` are 0.
- R2: The clock edge that first samples `pwr_good_i`=1 with `sleep_i`=0 starts the reset pulse. `panel_rst_n_o` stays 0 through that edge and the next RST_CYCLES edges, and it reads 1 after the (RST_CYCLES+1)-th edge.
- R3: After the reset is released, a settle window of SETTLE_CYCLES clock edges follows. No VSYNC edge in that window is counted, so no enable turns on because of it.
- R4: `vsync_n_i` is active low. Only a 1-to-0 transition counts, once, however long the low phase lasts. The input passes two synchroniser flops, so an edge first sampled low at edge k updates the count at edge k+2.
- R5: `ana_en_o` turns on at the 2nd counted VSYNC edge.
- R6: `cp_clk_en_o` turns on at the 3rd counted VSYNC edge.
- R7: `panel_out_en_o` turns on at the 9th counted VSYNC edge.
- R8: `pwm_en_o` turns on at the 11th counted VSYNC edge. Edges after the 11th change nothing.
- R9: `seq_done_o` is 1 exactly when all four enables are 1.
- R10: `sleep_i`=1 or `pwr_good_i`=0 sampled at an edge clears all enables and `seq_done_o` and drives `panel_rst_n_o` to 0 after that same edge.
- R11: When the abort condition clears, the complete sequence repeats from the reset pulse: reset length, settle window and counted edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pwr_good_i | input | 1 | Supply stable indication, synchronous to clk |
| sleep_i | input | 1 | Sleep request, synchronous to clk |
| vsync_n_i | input | 1 | Active-low vertical sync, asynchronous |
| panel_rst_n_o | output | 1 | Active-low global reset to the panel |
| ana_en_o | output | 1 | Analog supply enable |
| cp_clk_en_o | output | 1 | Charge pump clock enable |
| panel_out_en_o | output | 1 | Panel control and data output enable |
| pwm_en_o | output | 1 | Backlight boost PWM enable |
| seq_done_o | output | 1 | All enables active |

## Verification
The assertions assume that `pwr_good_i` and `sleep_i` are already synchronous to `clk`. They also assume that each VSYNC low and high phase lasts at least two clock cycles, so that the synchroniser sees every transition. The bench changes all inputs only on falling clock edges. Every VSYNC pulse it generates has a low phase of at least two cycles and a high phase of at least three, which keeps the stimulus within those assumptions.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_RESET  = 2'd1,
        SEQ_SETTLE = 2'd2,
        SEQ_ACTIVE = 2'd3
    } seq_state_e;

    localparam int unsigned NUM_ENABLES = 4;

endpackage

// File: rtl/pwrseq_vsync_edge.sv
module pwrseq_vsync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_n_i,
    output logic fall_o
);
    // chain_q[STAGES-1:0] synchronise; chain_q[STAGES] holds the prior value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], vsync_n_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

    // R4: a detected fall is never reported on two consecutive cycles
    p_single_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int unsigned RST_CYCLES    = 32000,
    parameter int unsigned SETTLE_CYCLES = 400000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    output seq_state_e state_o
);
    localparam int unsigned TMAX = (RST_CYCLES > SETTLE_CYCLES) ? RST_CYCLES : SETTLE_CYCLES;
    localparam int unsigned TW   = (TMAX < 2) ? 1 : $clog2(TMAX + 1);
    localparam logic [TW-1:0] RST_LAST    = TW'(RST_CYCLES - 1);
    localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CYCLES - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [TW-1:0] tmr;
    } fsm_regs_t;

    fsm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (!go_i) begin
            regs_d.st  = SEQ_IDLE;
            regs_d.tmr = '0;
        end else begin
            unique case (regs_q.st)
                SEQ_IDLE: begin
                    regs_d.st  = SEQ_RESET;
                    regs_d.tmr = '0;
                end
                SEQ_RESET: begin
                    if (regs_q.tmr == RST_LAST) begin
                        regs_d.st  = SEQ_SETTLE;
                        regs_d.tmr = '0;
                    end else begin
                        regs_d.tmr = regs_q.tmr + 1'b1;
                    end
                end
                SEQ_SETTLE: begin
                    if (regs_q.tmr == SETTLE_LAST) begin
                        regs_d.st  = SEQ_ACTIVE;
                        regs_d.tmr = '0;
                    end else begin
                        regs_d.tmr = regs_q.tmr + 1'b1;
                    end
                end
                default: begin
                    regs_d.tmr = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.st  <= SEQ_IDLE;
            regs_q.tmr <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o = regs_q.st;

    // R2: the reset phase never jumps straight to counting
    p_reset_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == SEQ_RESET) |=> (regs_q.st != SEQ_ACTIVE));

    // R3: counting is only reached through the settle window
    p_active_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == SEQ_ACTIVE && $past(regs_q.st) != SEQ_ACTIVE) |-> ($past(regs_q.st) == SEQ_SETTLE));

    // R10: an abort always lands in idle
    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> (regs_q.st == SEQ_IDLE));

endmodule

// File: rtl/pwrseq_vcount.sv
module pwrseq_vcount #(
    parameter int unsigned CNT_MAX = 11,
    localparam int unsigned CW     = $clog2(CNT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    output logic [CW-1:0] count_o
);
    localparam logic [CW-1:0] TOP = CW'(CNT_MAX);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)                    cnt_d = '0;
        else if (step_i && cnt_q < TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    // R4: the count advances by at most one per cycle
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    // R8: the count saturates at the last threshold
    p_count_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);

endmodule

// File: rtl/panel_pwrseq.sv
module panel_pwrseq
    import pwrseq_pkg::*;
#(
    parameter int unsigned RST_CYCLES    = 32000,
    parameter int unsigned SETTLE_CYCLES = 400000,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned VS_ANA        = 2,
    parameter int unsigned VS_CP         = 3,
    parameter int unsigned VS_PANEL      = 9,
    parameter int unsigned VS_PWM        = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good_i,
    input  logic sleep_i,
    input  logic vsync_n_i,
    output logic panel_rst_n_o,
    output logic ana_en_o,
    output logic cp_clk_en_o,
    output logic panel_out_en_o,
    output logic pwm_en_o,
    output logic seq_done_o
);
    localparam int unsigned CW = $clog2(VS_PWM + 1);
    localparam int unsigned THRESH [NUM_ENABLES] = '{VS_ANA, VS_CP, VS_PANEL, VS_PWM};

    seq_state_e          state;
    logic                go;
    logic                vs_fall;
    logic [CW-1:0]       vs_count;
    logic [NUM_ENABLES-1:0] en;

    assign go = pwr_good_i & ~sleep_i;

    pwrseq_vsync_edge #(.STAGES(SYNC_STAGES)) u_vsync_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync_n_i (vsync_n_i),
        .fall_o    (vs_fall)
    );

    pwrseq_fsm #(
        .RST_CYCLES    (RST_CYCLES),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .state_o (state)
    );

    pwrseq_vcount #(.CNT_MAX(VS_PWM)) u_vcount (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (!go || state != SEQ_ACTIVE),
        .step_i  (vs_fall),
        .count_o (vs_count)
    );

    for (genvar g = 0; g < NUM_ENABLES; g++) begin : g_en
        assign en[g] = (vs_count >= CW'(THRESH[g]));
    end

    assign panel_rst_n_o  = (state == SEQ_SETTLE) || (state == SEQ_ACTIVE);
    assign ana_en_o       = en[0];
    assign cp_clk_en_o    = en[1];
    assign panel_out_en_o = en[2];
    assign pwm_en_o       = en[3];
    assign seq_done_o     = (vs_count == CW'(VS_PWM));

    // R3: no subsystem is enabled while the panel is held in reset
    p_enable_after_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ana_en_o |-> panel_rst_n_o);

    // R6: charge pump clock never runs without the analog supply
    p_cp_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cp_clk_en_o |-> ana_en_o);

    // R7: panel outputs follow the charge pump
    p_panel_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        panel_out_en_o |-> cp_clk_en_o);

    // R8: the PWM is the last to come up
    p_pwm_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en_o |-> panel_out_en_o);

    // R9: done means every enable is on
    p_done_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |-> (&en));

    // R10: abort clears everything on the following cycle
    p_abort_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (!panel_rst_n_o && en == '0 && !seq_done_o));

endmodule

// File: tb/test_panel_pwrseq.sv
`timescale 1ns/1ps
module test_panel_pwrseq;
    localparam int R = 8;
    localparam int S = 12;

    logic clk = 1'b0;
    logic rst_n, pwr_good_i, sleep_i, vsync_n_i;
    logic panel_rst_n_o, ana_en_o, cp_clk_en_o, panel_out_en_o, pwm_en_o, seq_done_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    panel_pwrseq #(.RST_CYCLES(R), .SETTLE_CYCLES(S)) i_panel_pwrseq (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwr_good_i     (pwr_good_i),
        .sleep_i        (sleep_i),
        .vsync_n_i      (vsync_n_i),
        .panel_rst_n_o  (panel_rst_n_o),
        .ana_en_o       (ana_en_o),
        .cp_clk_en_o    (cp_clk_en_o),
        .panel_out_en_o (panel_out_en_o),
        .pwm_en_o       (pwm_en_o),
        .seq_done_o     (seq_done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 reset, 2 settle, 3 counting
    int m_phase = 0, m_time = 0, m_cnt = 0;
    bit m_last = 1'b1;
    bit m_pipe[$] = '{1'b0, 1'b0};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_time = 0; m_cnt = 0; m_last = 1'b1;
            m_pipe = '{1'b0, 1'b0};
        end else begin
            bit due;
            due = m_pipe.pop_front();
            m_pipe.push_back(m_last && !vsync_n_i);
            m_last = vsync_n_i;
            if (!pwr_good_i || sleep_i) begin
                m_phase = 0; m_time = 0; m_cnt = 0;
            end else if (m_phase == 0) begin
                m_phase = 1; m_time = 0;
            end else if (m_phase == 1 || m_phase == 2) begin
                m_time++;
                if (m_time == ((m_phase == 1) ? R : S)) begin
                    m_phase++; m_time = 0;
                end
            end else if (due && m_cnt < 11) begin
                m_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(panel_rst_n_o == (m_phase >= 2), "R2 reset line", panel_rst_n_o, m_phase >= 2);
            chk(ana_en_o == (m_cnt >= 2), "R5 analog enable", ana_en_o, m_cnt >= 2);
            chk(cp_clk_en_o == (m_cnt >= 3), "R6 charge pump enable", cp_clk_en_o, m_cnt >= 3);
            chk(panel_out_en_o == (m_cnt >= 9), "R7 panel output enable", panel_out_en_o, m_cnt >= 9);
            chk(pwm_en_o == (m_cnt >= 11), "R8 pwm enable", pwm_en_o, m_cnt >= 11);
            chk(seq_done_o == (m_cnt >= 11), "R9 done", seq_done_o, m_cnt >= 11);
        end
    end

    task automatic vs_pulse(input int lo, input int hi);
        @(negedge clk) vsync_n_i = 1'b0;
        repeat (lo) @(negedge clk);
        vsync_n_i = 1'b1;
        repeat (hi) @(negedge clk);
    endtask

    task automatic measure_release(input string req);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!panel_rst_n_o && n < 1000);
        chk(n == R + 1, req, n, R + 1);
    endtask

    task automatic all_off(input string req);
        int v;
        v = {panel_rst_n_o, ana_en_o, cp_clk_en_o, panel_out_en_o, pwm_en_o, seq_done_o};
        chk(v == 0, req, v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwr_good_i = 1'b0; sleep_i = 1'b0; vsync_n_i = 1'b1;
        repeat (3) @(negedge clk);
        all_off("R1 in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        all_off("R1 no power-good");

        // R2 reset pulse length
        pwr_good_i = 1'b1;
        measure_release("R2 reset length");

        // R3 an edge inside the settle window is not counted
        vs_pulse(2, 3);
        repeat (S) @(negedge clk);
        chk(ana_en_o == 0 && cp_clk_en_o == 0, "R3 settle edge ignored", ana_en_o, 0);

        vs_pulse(2, 4);
        vs_pulse(10, 4);   // long low phase counts once
        chk(ana_en_o == 1, "R5 second edge", ana_en_o, 1);
        chk(cp_clk_en_o == 0, "R4 long low counted once", cp_clk_en_o, 0);
        vs_pulse(2, 4);
        chk(cp_clk_en_o == 1, "R6 third edge", cp_clk_en_o, 1);
        chk(panel_out_en_o == 0, "R6 panel still off", panel_out_en_o, 0);
        for (int i = 0; i < 5; i++) vs_pulse(2, 3);
        chk(panel_out_en_o == 0, "R7 eighth edge", panel_out_en_o, 0);
        vs_pulse(2, 3);
        chk(panel_out_en_o == 1, "R7 ninth edge", panel_out_en_o, 1);
        chk(seq_done_o == 0, "R9 not yet done", seq_done_o, 0);
        vs_pulse(2, 3);
        chk(pwm_en_o == 0, "R8 tenth edge", pwm_en_o, 0);
        vs_pulse(2, 3);
        chk(pwm_en_o == 1, "R8 eleventh edge", pwm_en_o, 1);
        chk(seq_done_o == 1, "R9 done", seq_done_o, 1);
        vs_pulse(2, 3);
        chk(seq_done_o == 1 && pwm_en_o == 1, "R8 extra edge no effect", seq_done_o, 1);

        // R10 sleep abort, then R11 restart
        @(negedge clk) sleep_i = 1'b1;
        @(negedge clk);
        all_off("R10 sleep clears");
        sleep_i = 1'b0;
        measure_release("R11 restart reset length");
        repeat (S + 2) @(negedge clk);
        for (int i = 0; i < 5; i++) vs_pulse(2, 3);
        chk(cp_clk_en_o == 1 && panel_out_en_o == 0, "R11 partial restart", cp_clk_en_o, 1);

        // R10 power-good loss mid-sequence
        @(negedge clk) pwr_good_i = 1'b0;
        @(negedge clk);
        all_off("R10 power loss clears");
        repeat (3) @(negedge clk);
        all_off("R10 stays off");
        pwr_good_i = 1'b1;
        measure_release("R11 second restart");
        repeat (S + 2) @(negedge clk);
        for (int i = 0; i < 11; i++) vs_pulse(2, 3);
        chk(seq_done_o == 1, "R11 full sequence repeated", seq_done_o, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule